// File: doc/BRIEF.md
# Consumer Infrared Transmit Modulator

This block turns a stream of bytes into an on/off-keyed infrared drive signal. Every data bit is held for a bit time T. During T, a 1 bit produces a train of carrier pulses and a 0 bit produces a quiet line. The carrier is built from a clock-enable tick that runs at twelve times the carrier frequency. Each carrier period is therefore twelve sub-periods long. A 2-bit mode code sets how many of those sub-periods are high at the start of each period.

Bytes arrive on a valid/ready handshake. A byte is accepted only on a tick. When the next byte is already waiting as the current byte ends, it starts at once with no idle gap between the two. The block adds no framing of its own. Inter-byte spacing and bit encodings such as Manchester pairs are built by whoever supplies the data. T is given as a whole number of carrier periods. T, like the mode code, is captured when a byte is accepted.

Top module: `cirtx_modulator`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `ir_out` and `busy` are 0, and `in_ready` equals `tick`.
- R2: Within a 1 bit, each carrier period starts with `ir_out` high for 3, 4, 5 or 6 sub-periods, for `duty_mode` code 00, 01, 10 or 11 respectively. The line is low for the rest of the period.
- R3: A carrier period is exactly 12 ticks long, and a 1 bit holds exactly T back-to-back carrier periods.
- R4: A 0 bit keeps `ir_out` low for 12·T ticks.
- R5: The bits of a byte are sent least significant bit first, 8 bits per byte.
- R6: `bit_periods` gives T in carrier periods. A value of 0 behaves as 1.
- R7: `duty_mode` and `bit_periods` are captured on the clock edge where a byte is accepted. Changing them while the byte is being sent has no effect on that byte.
- R8: `in_ready` is high on a tick when the block is idle, and on the tick that ends the last sub-period of the current byte. If `in_valid` is high then, the next byte's first sub-period starts on that same edge.
- R9: Pulses are never cut short. `busy` stays high through the final sub-period of the last bit, and falls on the edge that ends it, unless a new byte is accepted on that edge.
- R10: While `busy` is 0, `ir_out` is 0.
- R11: State advances only on a tick. `ir_out` is a register and shows each sub-period one clock after the tick edge that begins it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sub-period enable, at 12 times the carrier rate |
| duty_mode | input | 2 | Duty code: 00=3/12, 01=4/12, 10=5/12, 11=6/12 |
| bit_periods | input | CNT_W | Bit time T in carrier periods (0 is treated as 1) |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | DATA_W | Byte to send, LSB first |
| in_ready | output | 1 | Byte is taken on this edge when `in_valid` is high |
| ir_out | output | 1 | Modulated infrared drive line, idle low |
| busy | output | 1 | A byte is being sent |

## Verification
The hardest case to reach from the ports is a handover at the last tick of a byte. It needs a tick, the final sub-period of the eighth bit and a waiting byte, all in the same cycle, and it must happen while the tick spacing is irregular. The stimulus keeps a queue of bytes offered without a break under random tick spacing, so every byte boundary becomes a handover. A second phase changes `duty_mode` and `bit_periods` on every clock while bytes are in flight, to show the captured values hold. The reference model counts ticks since the start of each byte and derives the bit, the phase and the level arithmetically. It is compared with the outputs on every clock.

// File: rtl/cirtx_pkg.sv
package cirtx_pkg;

  localparam int unsigned SUBS_PER_CARRIER = 12;
  localparam int unsigned PHASE_W          = 4;

  typedef enum logic [1:0] {
    DUTY_3_OF_12 = 2'b00,
    DUTY_4_OF_12 = 2'b01,
    DUTY_5_OF_12 = 2'b10,
    DUTY_6_OF_12 = 2'b11
  } duty_e;

  // Number of leading high sub-periods in one carrier period.
  function automatic logic [PHASE_W-1:0] high_subs(duty_e m);
    case (m)
      DUTY_3_OF_12: return PHASE_W'(3);
      DUTY_4_OF_12: return PHASE_W'(4);
      DUTY_5_OF_12: return PHASE_W'(5);
      default:      return PHASE_W'(6);
    endcase
  endfunction

endpackage

// File: rtl/cirtx_phase.sv
// Sub-period counter inside one carrier period.
module cirtx_phase
  import cirtx_pkg::*;
#(
  parameter int unsigned SUBS = SUBS_PER_CARRIER
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               run_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               wrap_o
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(SUBS - 1);

  logic [PHASE_W-1:0] phase_q;

  assign wrap_o  = tick && run_i && (phase_q == LAST);
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (tick && run_i) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/cirtx_bitseq.sv
// Counts carrier periods within a bit and bits within a byte.
module cirtx_bitseq #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] tlen_m1_i,
  output logic             bit_end_o,
  output logic             byte_end_o
);
  localparam int unsigned BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(DATA_W - 1);

  logic [CNT_W-1:0]  pcnt_q;
  logic [BIDX_W-1:0] bidx_q;

  assign bit_end_o  = wrap_i && (pcnt_q == tlen_m1_i);
  assign byte_end_o = bit_end_o && (bidx_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      pcnt_q <= '0;
      bidx_q <= '0;
    end else if (wrap_i) begin
      if (bit_end_o) begin
        pcnt_q <= '0;
        bidx_q <= bidx_q + 1'b1;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cirtx_frame.sv
// Holds the byte in flight and the settings captured with it.
module cirtx_frame
  import cirtx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              bit_end_i,
  input  logic [DATA_W-1:0] data_i,
  input  duty_e             mode_i,
  input  logic [CNT_W-1:0]  tlen_i,
  output logic              cur_bit_o,
  output duty_e             mode_o,
  output logic [CNT_W-1:0]  tlen_m1_o
);
  logic [DATA_W-1:0] shreg_q;
  duty_e             mode_q;
  logic [CNT_W-1:0]  tlen_m1_q;

  assign cur_bit_o = shreg_q[0];
  assign mode_o    = mode_q;
  assign tlen_m1_o = tlen_m1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q   <= '0;
      mode_q    <= DUTY_3_OF_12;
      tlen_m1_q <= '0;
    end else if (load_i) begin
      shreg_q   <= data_i;
      mode_q    <= mode_i;
      tlen_m1_q <= (tlen_i == '0) ? '0 : tlen_i - 1'b1;
    end else if (bit_end_i) begin
      shreg_q   <= shreg_q >> 1;
    end
  end
endmodule

// File: rtl/cirtx_modulator.sv
module cirtx_modulator
  import cirtx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        duty_mode,
  input  logic [CNT_W-1:0]  bit_periods,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              ir_out,
  output logic              busy
);
  logic               active_q;
  logic               ir_q;
  logic [PHASE_W-1:0] phase;
  logic               wrap;
  logic               bit_end;
  logic               byte_end;
  logic               load;
  logic               cur_bit;
  duty_e              mode_cur;
  logic [CNT_W-1:0]   tlen_m1;

  assign in_ready = tick && (!active_q || byte_end);
  assign load     = in_ready && in_valid;

  cirtx_phase #(.SUBS(SUBS_PER_CARRIER)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run_i   (active_q),
    .phase_o (phase),
    .wrap_o  (wrap)
  );

  cirtx_bitseq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_bitseq (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .wrap_i     (wrap),
    .tlen_m1_i  (tlen_m1),
    .bit_end_o  (bit_end),
    .byte_end_o (byte_end)
  );

  cirtx_frame #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .bit_end_i (bit_end),
    .data_i    (in_data),
    .mode_i    (duty_e'(duty_mode)),
    .tlen_i    (bit_periods),
    .cur_bit_o (cur_bit),
    .mode_o    (mode_cur),
    .tlen_m1_o (tlen_m1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ir_q     <= 1'b0;
    end else begin
      if (load)          active_q <= 1'b1;
      else if (byte_end) active_q <= 1'b0;
      ir_q <= active_q && cur_bit && (phase < high_subs(mode_cur));
    end
  end

  assign ir_out = ir_q;
  assign busy   = active_q;
endmodule

// File: rtl/cirtx_modulator_chk.sv
module cirtx_modulator_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic in_valid,
  input logic in_ready,
  input logic ir_out,
  input logic busy
);
  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ir_out); // R10

  AST_READY_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tick); // R11

  AST_IDLE_TAKES_BYTE: assert property (@(posedge clk) disable iff (rst)
    (!busy && tick) |-> in_ready); // R8

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> busy); // R8

  AST_BUSY_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> busy); // R9

  AST_LINE_STILL_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |=> $stable(ir_out)); // R11
endmodule

bind cirtx_modulator cirtx_modulator_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .ir_out   (ir_out),
  .busy     (busy)
);

// File: tb/cirtx_modulator_tb.sv
`timescale 1ns/1ps
module cirtx_modulator_tb;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int WDOG   = 190000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick = 1'b0;
  logic [1:0]       duty_mode = 2'b00;
  logic [CNT_W-1:0] bit_periods = 8'd1;
  logic             in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic             in_ready, ir_out, busy;

  always #2 clk = ~clk; // 250 MHz

  cirtx_modulator #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .duty_mode(duty_mode),
    .bit_periods(bit_periods), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ir_out(ir_out), .busy(busy)
  );

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  bit timeout = 0;
  string sec  = "R1";

  // stimulus configuration
  int tick_div   = 1;   // 0 = random ticks
  int valid_pct  = 100;
  bit churn_cfg  = 0;
  logic [7:0] pending[$];

  // reference model
  bit   m_act = 0;
  int   m_sub = 0;
  int   m_T   = 1;
  int   m_mode = 0;
  logic [7:0] m_byte = '0;
  logic m_ir = 1'b0;

  function automatic bit model_line();
    int bitn, ph;
    if (!m_act) return 1'b0;
    bitn = m_sub / (12 * m_T);
    ph   = m_sub % 12;
    return m_byte[bitn] && (ph < 3 + m_mode);
  endfunction

  function automatic bit model_ready();
    return tick && (!m_act || m_sub == 12 * DATA_W * m_T - 1);
  endfunction

  task automatic check(string tag, string what, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic step();
    bit acc, rdy, nl;
    @(negedge clk);
    cyc++;
    if (cyc > WDOG) begin
      if (!timeout) begin
        errors++;
        $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, WDOG);
      end
      timeout = 1;
      return;
    end
    // outputs produced by the previous edge
    check(m_act ? (model_line() ? "R2 R3" : "R4") : "R10", {sec, " ir_out"}, ir_out, m_ir);
    check("R9", {sec, " busy"}, busy, m_act);
    // drive new inputs
    if (tick_div == 0) tick = ($urandom_range(0, 2) != 0);
    else               tick = (cyc % tick_div == 0);
    if (churn_cfg) begin
      duty_mode   = 2'($urandom_range(0, 3));
      bit_periods = 8'($urandom_range(0, 3));
    end
    in_valid = (pending.size() > 0) && ($urandom_range(1, 100) <= valid_pct);
    in_data  = (pending.size() > 0) ? pending[0] : 8'h00;
    #1;
    rdy = model_ready();
    check("R8", {sec, " in_ready"}, in_ready, rdy);
    @(posedge clk);
    nl  = model_line();
    acc = rdy && in_valid;
    if (tick && m_act) begin
      m_sub++;
      if (m_sub == 12 * DATA_W * m_T) m_act = 0;
    end
    if (acc) begin
      m_act  = 1;
      m_sub  = 0;
      m_byte = in_data;
      m_mode = duty_mode;
      m_T    = (bit_periods == 0) ? 1 : bit_periods;
      void'(pending.pop_front());
    end
    m_ir = nl;
  endtask

  task automatic drain();
    while (!timeout && (pending.size() > 0 || m_act)) step();
    for (int i = 0; i < 4 && !timeout; i++) step();
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      tick = i[0];
      #1;
      if (i > 0) begin
        check("R1", "reset ir_out", ir_out, 1'b0);
        check("R1", "reset busy", busy, 1'b0);
      end
      check("R1", "reset in_ready", in_ready, tick);
    end
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) step();

    // R2 R3: all-ones bytes, each duty code, tick every cycle
    sec = "R2 R3";
    for (int m = 0; m < 4 && !timeout; m++) begin
      duty_mode = 2'(m);
      bit_periods = 8'd1;
      pending.push_back(8'hFF);
      drain();
    end

    // R4 R5: bit order and blank bits, T=2, tick every other cycle
    sec = "R4 R5";
    tick_div = 2; duty_mode = 2'b01; bit_periods = 8'd2;
    pending.push_back(8'h01); drain();
    pending.push_back(8'h80); drain();
    pending.push_back(8'h5A); drain();

    // R6: zero and larger bit times
    sec = "R6";
    tick_div = 1; duty_mode = 2'b11;
    bit_periods = 8'd0; pending.push_back(8'hC3); drain();
    bit_periods = 8'd3; pending.push_back(8'hC3); drain();

    // R7: settings changed every clock while bytes are in flight
    sec = "R7";
    churn_cfg = 1; tick_div = 0;
    pending.push_back(8'h96); pending.push_back(8'h3C); pending.push_back(8'hE1);
    drain();
    churn_cfg = 0;

    // R8: back-to-back stream with irregular ticks
    sec = "R8";
    duty_mode = 2'b10; bit_periods = 8'd1;
    for (int i = 0; i < 6; i++) pending.push_back(8'(8'h11 * (i + 3)));
    drain();

    // R9 R11: gaps in valid, random ticks, settings churn
    sec = "R9 R11";
    valid_pct = 30; churn_cfg = 1;
    for (int i = 0; i < 8; i++) pending.push_back(8'($urandom_range(0, 255)));
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule